// File: doc/BRIEF.md
# Gray-Coded Time-Slice Hit Stamper

This block attaches a coarse arrival time to each hit in a group of pixels during one acquisition window. A single shared counter at the edge of the array splits the window into equal time slices. It advances once every `PRESCALE` system clocks and publishes the current slice number to every pixel as a Gray code. A capture taken at any moment therefore sees at most one bit in motion.

Each pixel keeps exactly one stamp, which is a pipeline depth of one. The first hit of a window freezes the code present at that moment, and later hits are ignored until the next window begins. A window start pulse resets the counter to slice zero and clears every pixel. After the last slice the counter stays on the final code until the next start.

A readout port selects one pixel and returns its stamp converted back to binary, together with its valid flag. The slice width is a parameter: 5 bits gives 32 slices, and 6 bits extends the window to 64.

Top module: `slice_stamper`

## Requirements
- R1: After reset, `slice_gray` is 0, every bit of `stamp_valid` is 0, and every stamp in `stamps` is 0.
- R2: A `win_start` pulse sets the slice to 0 on the following edge. From then on the binary slice number rises by one after every `PRESCALE` clock edges, so t edges after the start edge the slice is floor(t/PRESCALE).
- R3: `slice_gray` carries the slice s encoded as s XOR (s>>1). Every change that is not caused by a start flips exactly one bit.
- R4: Once the slice reaches 2^SLICE_W-1 (Gray 10000 for 5 bits), `slice_gray` holds that value until the next `win_start`.
- R5: When `hit[i]` is high at an edge inside an open window and pixel i holds no stamp, pixel i stores the `slice_gray` value present before that edge and sets `stamp_valid[i]`. Pixel i's stamp sits at bits [i*SLICE_W +: SLICE_W] of `stamps`.
- R6: Further hits on a pixel that already holds a stamp change neither its stamp nor its valid flag.
- R7: Hits before the first `win_start` after reset are ignored. A `win_start` clears all stamps and valid flags, and a hit in the same cycle as a start is ignored.
- R8: `rd_bin` is the selected pixel's stamp converted from Gray to binary, and `rd_valid` is that pixel's valid flag. Both are combinational from `rd_sel`.
- R9: A `win_start` in the middle of a window restarts the slice count at 0, and stamps taken afterwards are relative to the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_start | input | 1 | Pulse that opens a new acquisition window |
| hit | input | N_PIX | Per-pixel hit strobes |
| rd_sel | input | SEL_W | Pixel index for readout |
| slice_gray | output | SLICE_W | Broadcast slice code, Gray encoded |
| stamps | output | N_PIX*SLICE_W | All stored stamps (Gray), pixel i at bits [i*SLICE_W +: SLICE_W] |
| stamp_valid | output | N_PIX | Per-pixel stamp-held flags |
| rd_bin | output | SLICE_W | Selected stamp converted to binary |
| rd_valid | output | 1 | Valid flag of the selected pixel |

## Verification
A full-window sweep follows the broadcast code edge by edge from slice 0 to past the last slice. It separates a correct Gray encoding and step rate from off-by-one prescaling, from a wrapping counter and from multi-bit transitions. Hits are placed on the first edge, on both sides of a slice boundary and after the final slice, which exposes any capture that is one cycle early or late. Repeated hits, hits before any window and hits that coincide with a start distinguish a first-hit-wins pixel from one that overwrites or one that ignores the clear. Reading every pixel back in binary checks both the readout selection and the Gray-to-binary conversion.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
    localparam int CODE_MAX_W = 8;
    typedef logic [CODE_MAX_W-1:0] code_t;

    function automatic code_t bin_to_gray(code_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic code_t gray_to_bin(code_t g);
        code_t b;
        b[CODE_MAX_W-1] = g[CODE_MAX_W-1];
        for (int k = CODE_MAX_W - 2; k >= 0; k--) begin
            b[k] = b[k+1] ^ g[k];
        end
        return b;
    endfunction
endpackage

// File: rtl/gray_slice_counter.sv
module gray_slice_counter
    import stamp_pkg::*;
#(
    parameter int SLICE_W  = 5,
    parameter int PRESCALE = 3125
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic [SLICE_W-1:0] gray_o,
    output logic               open_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
    localparam logic [SLICE_W-1:0] SLICE_LAST = {SLICE_W{1'b1}};

    typedef struct packed {
        logic               open;
        logic               run;
        logic [PW-1:0]      presc;
        logic [SLICE_W-1:0] bin;
        logic [SLICE_W-1:0] gray;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    code_t      gray_full;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.open  = 1'b1;
            st_d.run   = 1'b1;
            st_d.presc = '0;
            st_d.bin   = '0;
        end else if (st_q.run) begin
            if (st_q.presc == PRE_LAST) begin
                st_d.presc = '0;
                st_d.bin   = st_q.bin + 1'b1;
                if (st_q.bin == SLICE_LAST - 1'b1) begin
                    st_d.run = 1'b0;
                end
            end else begin
                st_d.presc = st_q.presc + 1'b1;
            end
        end
        gray_full = bin_to_gray(code_t'(st_d.bin));
        st_d.gray = gray_full[SLICE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gray_o = st_q.gray;
    assign open_o = st_q.open;

    assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (gray_o == '0));

    assert_one_bit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_i) && !$stable(gray_o)) |-> ($countones(gray_o ^ $past(gray_o)) == 1));

    assert_hold_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bin == SLICE_LAST && !start_i) |=> $stable(gray_o));
endmodule

// File: rtl/pixel_stamp_cell.sv
module pixel_stamp_cell #(
    parameter int SLICE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               open_i,
    input  logic               hit_i,
    input  logic [SLICE_W-1:0] code_i,
    output logic [SLICE_W-1:0] stamp_o,
    output logic               valid_o
);
    typedef struct packed {
        logic               valid;
        logic [SLICE_W-1:0] stamp;
    } cell_state_t;

    cell_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (start_i) begin
            cs_d.valid = 1'b0;
            cs_d.stamp = '0;
        end else if (open_i && hit_i && !cs_q.valid) begin
            cs_d.valid = 1'b1;
            cs_d.stamp = code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign stamp_o = cs_q.stamp;
    assign valid_o = cs_q.valid;

    assert_keep_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !start_i) |=> (valid_o && $stable(stamp_o)));

    assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!valid_o && stamp_o == '0));
endmodule

// File: rtl/stamp_readout.sv
module stamp_readout
    import stamp_pkg::*;
#(
    parameter int N_PIX   = 8,
    parameter int SLICE_W = 5,
    parameter int SEL_W   = 3
) (
    input  logic [N_PIX*SLICE_W-1:0] stamps_i,
    input  logic [N_PIX-1:0]         valid_i,
    input  logic [SEL_W-1:0]         sel_i,
    output logic [SLICE_W-1:0]       bin_o,
    output logic                     valid_o
);
    logic [SLICE_W-1:0] pick;
    code_t              bin_full;

    always_comb begin
        pick    = '0;
        valid_o = 1'b0;
        for (int i = 0; i < N_PIX; i++) begin
            if (int'(sel_i) == i) begin
                pick    = stamps_i[i*SLICE_W +: SLICE_W];
                valid_o = valid_i[i];
            end
        end
        bin_full = gray_to_bin(code_t'(pick));
        bin_o    = bin_full[SLICE_W-1:0];
    end
endmodule

// File: rtl/slice_stamper.sv
module slice_stamper #(
    parameter int N_PIX    = 8,
    parameter int SLICE_W  = 5,
    parameter int PRESCALE = 3125,
    localparam int SEL_W   = (N_PIX > 1) ? $clog2(N_PIX) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     win_start,
    input  logic [N_PIX-1:0]         hit,
    input  logic [SEL_W-1:0]         rd_sel,
    output logic [SLICE_W-1:0]       slice_gray,
    output logic [N_PIX*SLICE_W-1:0] stamps,
    output logic [N_PIX-1:0]         stamp_valid,
    output logic [SLICE_W-1:0]       rd_bin,
    output logic                     rd_valid
);
    logic win_open;

    gray_slice_counter #(.SLICE_W(SLICE_W), .PRESCALE(PRESCALE)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start_i(win_start),
        .gray_o(slice_gray), .open_o(win_open)
    );

    for (genvar i = 0; i < N_PIX; i++) begin : g_pix
        pixel_stamp_cell #(.SLICE_W(SLICE_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .start_i(win_start), .open_i(win_open),
            .hit_i(hit[i]), .code_i(slice_gray),
            .stamp_o(stamps[i*SLICE_W +: SLICE_W]), .valid_o(stamp_valid[i])
        );
    end

    stamp_readout #(.N_PIX(N_PIX), .SLICE_W(SLICE_W), .SEL_W(SEL_W)) u_rd (
        .stamps_i(stamps), .valid_i(stamp_valid), .sel_i(rd_sel),
        .bin_o(rd_bin), .valid_o(rd_valid)
    );

    assert_closed_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !win_start) |=> (stamp_valid == '0));
endmodule

// File: tb/sim_slice_stamper.sv
module sim_slice_stamper;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 8;
    localparam int SW  = 5;
    localparam int PS  = 4;
    localparam int LAST = (1 << SW) - 1;

    logic clk = 0, rst_n = 0, win_start = 0;
    logic [NP-1:0] hit = '0;
    logic [2:0] rd_sel = '0;
    logic [SW-1:0] slice_gray, rd_bin;
    logic [NP*SW-1:0] stamps;
    logic [NP-1:0] stamp_valid;
    logic rd_valid;

    int n_chk = 0, n_fail = 0, t = 0;
    int exp_slice [NP];
    bit exp_valid [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    slice_stamper #(.N_PIX(NP), .SLICE_W(SW), .PRESCALE(PS)) u0 (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .hit(hit), .rd_sel(rd_sel),
        .slice_gray(slice_gray), .stamps(stamps), .stamp_valid(stamp_valid),
        .rd_bin(rd_bin), .rd_valid(rd_valid)
    );

    function automatic int gray(int s); return s ^ (s >> 1); endfunction
    function automatic int slice_at(int k);
        int s = k / PS;
        return (s > LAST) ? LAST : s;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(); @(posedge clk); #1; t++; endtask

    task automatic do_start(logic [NP-1:0] with_hits);
        win_start = 1; hit = with_hits;
        step();
        win_start = 0; hit = '0; t = 0;
        for (int i = 0; i < NP; i++) begin exp_valid[i] = 0; exp_slice[i] = 0; end
    endtask

    task automatic pulse(logic [NP-1:0] m);
        hit = m; step(); hit = '0;
        for (int i = 0; i < NP; i++)
            if (m[i] && !exp_valid[i]) begin exp_valid[i] = 1; exp_slice[i] = slice_at(t-1); end
    endtask

    task automatic check_pixels(string req);
        for (int i = 0; i < NP; i++) begin
            check(req, int'(stamp_valid[i]), int'(exp_valid[i]));
            check(req, int'(stamps[i*SW +: SW]), exp_valid[i] ? gray(exp_slice[i]) : 0);
        end
    endtask

    task automatic t_reset();
        check("R1", int'(slice_gray), 0);
        check("R1", int'(stamp_valid), 0);
        check("R1", (stamps == '0) ? 1 : 0, 1);
        pulse(8'h01); pulse(8'hFF);
        for (int i = 0; i < NP; i++) exp_valid[i] = 0;
        check("R7 pre-start hit ignored", int'(stamp_valid), 0);
    endtask

    task automatic t_sweep();
        int prev;
        do_start('0);
        check("R2 start gives zero", int'(slice_gray), 0);
        prev = 0;
        for (int k = 0; k < (LAST + 4) * PS; k++) begin
            step();
            check("R2 R3 R4 slice code", int'(slice_gray), gray(slice_at(t)));
            if (int'(slice_gray) != prev)
                check("R3 one-bit change", $countones(int'(slice_gray) ^ prev), 1);
            prev = int'(slice_gray);
        end
        check("R4 final code", int'(slice_gray), 16);
    endtask

    task automatic t_capture();
        do_start('0);
        pulse(8'h01);
        while (t < PS - 1) step();
        pulse(8'h02);
        pulse(8'h04);
        while (t < 5 * PS + 2) step();
        pulse(8'h08);
        check_pixels("R5 capture timing");
        pulse(8'h0F);
        while (t < 9 * PS) step();
        pulse(8'h01);
        check_pixels("R6 repeat hits ignored");
        while (t < 40 * PS) step();
        pulse(8'h30);
        check_pixels("R4 R5 capture after last slice");
    endtask

    task automatic t_readout();
        for (int i = 0; i < NP; i++) begin
            rd_sel = 3'(i); #1;
            check("R8 rd_valid", int'(rd_valid), int'(exp_valid[i]));
            check("R8 rd_bin", int'(rd_bin), exp_valid[i] ? exp_slice[i] : 0);
        end
    endtask

    task automatic t_restart();
        do_start('0);
        while (t < 7 * PS) step();
        pulse(8'h04);
        while (t < 11 * PS + 1) step();
        do_start(8'h08);
        check_pixels("R7 start clears, coincident hit ignored");
        check("R9 restart slice", int'(slice_gray), 0);
        pulse(8'h08);
        while (t < 3 * PS) step();
        pulse(8'h80);
        check_pixels("R9 stamps relative to new start");
    endtask

    initial begin
        for (int i = 0; i < NP; i++) begin exp_valid[i] = 0; exp_slice[i] = 0; end
        #(CLK_PERIOD*2 + 1); rst_n = 1; #(CLK_PERIOD);
        t_reset();
        t_sweep();
        t_capture();
        t_readout();
        t_restart();
        t_readout();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule